// File: doc/BRIEF.md
# Predicted Subcache Probe Controller

This block decides which subcache of a partitioned second-level cache is powered up and probed for a request. The lookup starts in a single subcache, not in all banks at once. If the primary predictor returns a valid identifier, the probe starts in that subcache. If the predictor has no opinion, a small address hash picks the starting subcache. Only one subcache enable is driven at a time. The tag compare is limited to the ways that are currently powered inside that subcache.

The per-way tag equality results for the enabled subcache come back in the same cycle. A match counts only if it falls in an active way. On a miss, the controller walks the remaining subcaches one per cycle in ascending index order, wrapping around, and flags each extra probe as a reprobe. When the request resolves, the block pulses a completion signal and reports three things: the hit result, the number of extra probe cycles, and, when the data turned up somewhere other than the first guess, a training update that carries the correct subcache identifier.

Top module: `subcache_probe_ctrl`

## Requirements
- R1: After reset, `busy`, `sub_en`, `cmp_mask`, `done` and `upd_valid` are all low.
- R2: A request accepted with `pred_valid`=1 enables subcache `pred_id` in the first probe cycle. That cycle is the cycle after the request edge.
- R3: A request accepted with `pred_valid`=0 enables the subcache given by the hash `req_addr[5:4] ^ req_addr[7:6]` in the first probe cycle. This holds for the default parameters, with the index fields starting at bit OFF=4.
- R4: While `busy` is high, exactly one bit of `sub_en` is set. While `busy` is low, `sub_en` is zero.
- R5: `cmp_mask` equals the active-way mask of the enabled subcache, which is `active_ways[s*WAYS +: WAYS]` for subcache s. A `tag_eq` bit counts as a hit only where `cmp_mask` is set.
- R6: After a miss, the next cycle probes subcache (s+1) mod N_SUB. `reprobe` is high in every probe cycle except the first.
- R7: One cycle after the resolving probe, `done` pulses for one cycle and `busy` is low. On a hit, `hit`=1 and `extra_cycles` is the number of probes minus one. After all N_SUB subcaches miss, `hit`=0 and `extra_cycles`=N_SUB-1.
- R8: `upd_valid` pulses together with `done` exactly when the hit was found in a subcache other than the first one probed. `upd_id` then holds that subcache's index.
- R9: A request raised while `busy` is high is ignored. The probe order and the result of the current request are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New lookup request (taken only when idle) |
| req_addr | input | ADDR_W | Request address |
| pred_valid | input | 1 | Primary predictor has an identifier |
| pred_id | input | log2(N_SUB) | Predicted subcache index |
| active_ways | input | N_SUB*WAYS | Powered-way mask per subcache |
| tag_eq | input | WAYS | Per-way tag equality from the enabled subcache |
| busy | output | 1 | Probe in progress |
| sub_en | output | N_SUB | Subcache enables |
| cmp_mask | output | WAYS | Ways allowed in the tag compare |
| reprobe | output | 1 | Current probe is not the first |
| done | output | 1 | Request resolved (one-cycle pulse) |
| hit | output | 1 | Result of the resolved request |
| extra_cycles | output | log2(N_SUB) | Probes beyond the first |
| upd_valid | output | 1 | Predictor training update |
| upd_id | output | log2(N_SUB) | Correct subcache for the update |

## Verification
The hardest case to reach is a long reprobe chain. It needs the data to sit in the subcache just before the starting one in wrap order, in a way that is powered. A second hard case is a tag match that lands in a powered-down way, which must be treated as a miss. The bench plays the tag arrays itself: for each request it picks a home subcache and way and answers `tag_eq` from the live `sub_en`. Random homes, predictions and way masks are mixed with directed requests that place the data at the last wrap position, in an inactive way, or nowhere at all. A second request is injected in the middle of a probe to exercise R9.

// File: rtl/subcache_probe_ctrl.sv
module subcache_probe_ctrl #(
  parameter int N_SUB  = 4,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  parameter int OFF    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    pred_valid,
  input  logic [$clog2(N_SUB)-1:0] pred_id,
  input  logic [N_SUB*WAYS-1:0]   active_ways,
  input  logic [WAYS-1:0]         tag_eq,
  output logic                    busy,
  output logic [N_SUB-1:0]        sub_en,
  output logic [WAYS-1:0]         cmp_mask,
  output logic                    reprobe,
  output logic                    done,
  output logic                    hit,
  output logic [$clog2(N_SUB)-1:0] extra_cycles,
  output logic                    upd_valid,
  output logic [$clog2(N_SUB)-1:0] upd_id
);
  localparam int SW = $clog2(N_SUB);

  logic [SW-1:0] cur_q, cnt_q;
  logic [SW-1:0] hash_idx, start_idx;
  logic          probe_hit, last, finish;

  assign hash_idx  = req_addr[OFF +: SW] ^ req_addr[OFF+SW +: SW];
  assign start_idx = pred_valid ? pred_id : hash_idx;

  assign sub_en    = busy ? (N_SUB'(1) << cur_q) : '0;
  assign cmp_mask  = busy ? active_ways[cur_q*WAYS +: WAYS] : '0;
  assign reprobe   = busy && (cnt_q != '0);
  assign probe_hit = busy && |(tag_eq & cmp_mask);
  assign last      = cnt_q == SW'(N_SUB-1);
  assign finish    = busy && (probe_hit || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      cur_q        <= '0;
      cnt_q        <= '0;
      done         <= 1'b0;
      hit          <= 1'b0;
      extra_cycles <= '0;
      upd_valid    <= 1'b0;
      upd_id       <= '0;
    end else begin
      done      <= finish;
      upd_valid <= probe_hit && (cnt_q != '0);
      if (finish) begin
        hit          <= probe_hit;
        extra_cycles <= cnt_q;
        upd_id       <= cur_q;
      end
      if (!busy) begin
        if (req_valid) begin
          busy  <= 1'b1;
          cur_q <= start_idx;
          cnt_q <= '0;
        end
      end else if (finish) begin
        busy <= 1'b0;
      end else begin
        cur_q <= cur_q + 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module subcache_probe_chk #(
  parameter int N_SUB = 4,
  parameter int WAYS  = 4,
  parameter int SW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             pred_valid,
  input logic [SW-1:0]    pred_id,
  input logic             busy,
  input logic [N_SUB-1:0] sub_en,
  input logic             reprobe,
  input logic             done,
  input logic             hit,
  input logic [SW-1:0]    extra_cycles,
  input logic             upd_valid
);
  // R4
  onehot_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(sub_en) == 1);
  // R4
  idle_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sub_en == '0);
  // R2
  pred_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && pred_valid) |=> sub_en == (N_SUB'(1) << $past(pred_id)));
  // R6
  reprobe_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reprobe) |-> $past(busy) && sub_en == {$past(sub_en[N_SUB-2:0]), $past(sub_en[N_SUB-1])});
  // R7
  miss_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> extra_cycles == SW'(N_SUB-1));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  // R8
  upd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> done && hit && extra_cycles != '0);
endmodule

bind subcache_probe_ctrl subcache_probe_chk #(.N_SUB(N_SUB), .WAYS(WAYS), .SW($clog2(N_SUB))) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pred_valid(pred_valid),
  .pred_id(pred_id), .busy(busy), .sub_en(sub_en), .reprobe(reprobe),
  .done(done), .hit(hit), .extra_cycles(extra_cycles), .upd_valid(upd_valid));

// File: tb/test_subcache_probe_ctrl.sv
module test_subcache_probe_ctrl;
  localparam int N = 4, W = 4, AW = 16, SW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, pred_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] pred_id = '0;
  logic [N*W-1:0] active_ways = '1;
  logic [W-1:0] tag_eq;
  logic busy, reprobe, done, hit, upd_valid;
  logic [N-1:0] sub_en;
  logic [W-1:0] cmp_mask;
  logic [SW-1:0] extra_cycles, upd_id;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit home_ok = 0;
  int home = 0, way = 0;

  always #5 clk = ~clk;

  subcache_probe_ctrl #(.N_SUB(N), .WAYS(W), .ADDR_W(AW), .OFF(4)) i_subcache_probe_ctrl (
    .clk, .rst_n, .req_valid, .req_addr, .pred_valid, .pred_id, .active_ways, .tag_eq,
    .busy, .sub_en, .cmp_mask, .reprobe, .done, .hit, .extra_cycles, .upd_valid, .upd_id);

  always_comb tag_eq = (home_ok && sub_en[home]) ? W'(1 << way) : '0;

  function automatic int hashf(logic [AW-1:0] a);
    return int'(a[5:4] ^ a[7:6]);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(logic [AW-1:0] a, bit pv, int pid, bit hok, int hm, int wy, bit inject);
    int first, probes, i;
    bit exp_hit;
    first = pv ? pid : hashf(a);
    exp_hit = hok && active_ways[hm*W + wy];
    probes = exp_hit ? ((hm - first + N) % N) + 1 : N;
    @(negedge clk);
    home_ok = hok; home = hm; way = wy;
    req_addr = a; pred_valid = pv; pred_id = SW'(pid); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    i = 0;
    while (!done && i < N + 2) begin
      int s = (first + i) % N;
      chk(busy == 1, "R4 busy", busy, 1);
      chk(sub_en == N'(1 << s), i == 0 ? (pv ? "R2 first subcache" : "R3 hash subcache") : "R6 next subcache", sub_en, 1 << s);
      chk(cmp_mask == active_ways[s*W +: W], "R5 cmp_mask", cmp_mask, active_ways[s*W +: W]);
      chk(reprobe == (i != 0), "R6 reprobe", reprobe, i != 0);
      if (inject && i == 0) begin
        req_valid = 1; pred_valid = 1; pred_id = SW'(first + 2); req_addr = ~a;
      end else req_valid = 0;
      i++;
      @(negedge clk);
    end
    req_valid = 0;
    chk(i == probes, inject ? "R9 probe count" : "R7 probe count", i, probes);
    chk(done == 1 && busy == 0, "R7 done", done, 1);
    chk(hit == exp_hit, "R7 hit", hit, exp_hit);
    chk(extra_cycles == SW'(probes - 1), "R7 extra", extra_cycles, probes - 1);
    chk(upd_valid == (exp_hit && probes > 1), "R8 upd_valid", upd_valid, exp_hit && probes > 1);
    if (exp_hit && probes > 1) chk(upd_id == SW'(hm), "R8 upd_id", upd_id, hm);
    @(negedge clk);
    chk(done == 0 && upd_valid == 0, "R7 done pulse", done, 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && sub_en == 0 && cmp_mask == 0, "R1 reset outputs", sub_en, 0);
    chk(done == 0 && upd_valid == 0, "R1 reset status", done, 0);
    // directed corner cases
    active_ways = '1;
    run(16'h0000, 1, 2, 1, 2, 1, 0);          // R2 hit in predicted subcache
    run(16'h0070, 0, 0, 1, 3, 0, 0);          // R3 hash 3^1=2, hit one reprobe later
    run(16'h0000, 1, 1, 1, 0, 3, 0);          // R6 wrap to last position
    run(16'h0000, 1, 3, 0, 0, 0, 0);          // R7 miss everywhere
    active_ways = 16'hFFFF & ~(16'h1 << (1*W + 2));
    run(16'h0000, 1, 1, 1, 1, 2, 0);          // R5 match in powered-down way
    active_ways = '1;
    run(16'h0000, 1, 0, 1, 3, 1, 1);          // R9 injected request
    for (int t = 0; t < 300; t++) begin
      active_ways = N*W'($urandom);
      run(AW'($urandom), 1'($urandom), int'($urandom % N), ($urandom % 5) != 0,
          int'($urandom % N), int'($urandom % W), ($urandom % 4) == 0);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule